// File: doc/BRIEF.md
# MESI Line State Controller

This block decides what happens to one data cache line when the processor reads or writes it. It takes the line's present coherency state (Modified, Exclusive, Shared or Invalid), the type of access and the attribute bits that come with that access. From these it returns the state the line should take, the kind of bus cycle the access needs and whether the line stays in the cache afterwards. It has no registers, so all results are valid in the same cycle as the request.

The attribute bits are an active-low cacheability request and an active-low external cache-enable. They are joined by a writeback/writethrough indication (1 means writeback) and a page-level writethrough bit. A separate enable and a region-qualifier bit select write-allocate handling for a write miss. The region qualifier is decided outside the block. Under write-allocate, the miss is first resolved as a read fill to find an intermediate state. The write-hit rules are then applied to that intermediate state. Tag lookup and data storage belong to the surrounding cache.

Top module: `mesi_state_ctrl`

## Requirements
- R1: A read whose line state is M, E or S returns that same state with bus kind none (0). State codes are I=0, S=1, E=2, M=3.
- R2: A read of an I line with cache_req_n=0, ken_n=0, wb_wt=1 and pwt=0 returns E with bus kind line fill (1).
- R3: A read of an I line with cache_req_n=0 and ken_n=0, and with either wb_wt=0 or pwt=1, returns S with bus kind line fill (1).
- R4: A read of an I line with cache_req_n=1 or ken_n=1 returns I with bus kind line fill (1) and cacheable=0.
- R5: A write to an M or E line returns M with bus kind none (0).
- R6: A write to an S line issues a single write (2). It returns E when wb_wt=1 and pwt=0, and S otherwise.
- R7: A write to an I line without allocation (wa_enable=0 or wa_region=0) returns I with bus kind single write (2).
- R8: An allocating write miss (wa_enable=1 and wa_region=1) whose read-fill outcome would be E returns M with bus kind line fill (1), because the write is absorbed by the line.
- R9: An allocating write miss whose read-fill outcome would be S or I returns that same state with bus kind fill-then-write (3).
- R10: cacheable is 1 exactly when the returned state is not I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_write | input | 1 | 1 = write access, 0 = read access |
| line_state | input | 2 | Present line state (I=0, S=1, E=2, M=3) |
| cache_req_n | input | 1 | Cacheability request, active low |
| ken_n | input | 1 | External cache enable, active low |
| wb_wt | input | 1 | 1 = writeback, 0 = writethrough |
| pwt | input | 1 | Page writethrough bit |
| wa_enable | input | 1 | Write-allocate mode enable |
| wa_region | input | 1 | Access lies in an allocatable region |
| next_state | output | 2 | State the line takes after the access |
| bus_kind | output | 2 | 0 none, 1 line fill, 2 single write, 3 fill-then-write |
| cacheable | output | 1 | Line is held in the cache after the access |

## Verification
The read-fill rule and the write-hit rule both act on a single allocating write miss. The fill picks an intermediate state, and the write rule then turns that state into the final one, all in one cycle. The bench reaches this by sweeping every write to an I line with both allocation bits set, across all attribute combinations. Its behavioural model checks the final state together with the bus kind: an intermediate E must collapse to M with only a fill, and an intermediate S or I must keep its state and add the write.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   localparam int unsigned ST_W  = 2;
   localparam int unsigned BUS_W = 2;

   typedef enum logic [ST_W-1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } mesi_e;

   typedef enum logic [BUS_W-1:0] {
      BUS_NONE  = 2'd0,
      BUS_FILL  = 2'd1,
      BUS_WRITE = 2'd2,
      BUS_FILLW = 2'd3
   } bus_e;

   typedef struct packed {
      logic cache_req_n;
      logic ken_n;
      logic wb_wt;
      logic pwt;
   } attr_t;

endpackage

// File: rtl/mesi_fill_rule.sv
module mesi_fill_rule
   import mesi_pkg::*;
(
   input  attr_t attr,
   output mesi_e fill_state
);

   logic kept;
   logic wb_mode;

   always_comb begin
      kept    = ~attr.cache_req_n & ~attr.ken_n;
      wb_mode = attr.wb_wt & ~attr.pwt;
      if (!kept)
         fill_state = ST_I;
      else if (wb_mode)
         fill_state = ST_E;
      else
         fill_state = ST_S;
   end

endmodule

// File: rtl/mesi_write_rule.sv
module mesi_write_rule
   import mesi_pkg::*;
(
   input  mesi_e cur,
   input  attr_t attr,
   output mesi_e nxt,
   output logic  bus_wr
);

   always_comb begin
      unique case (cur)
         ST_M: begin nxt = ST_M; bus_wr = 1'b0; end
         ST_E: begin nxt = ST_M; bus_wr = 1'b0; end
         ST_S: begin
            bus_wr = 1'b1;
            nxt    = (attr.wb_wt && !attr.pwt) ? ST_E : ST_S;
         end
         default: begin nxt = ST_I; bus_wr = 1'b1; end
      endcase
   end

endmodule

// File: rtl/mesi_state_ctrl.sv
module mesi_state_ctrl
   import mesi_pkg::*;
#(
   parameter bit          WA_SUPPORT = 1'b1,
   parameter int unsigned STATE_W    = 2,
   parameter int unsigned KIND_W     = 2
)(
   input  logic               acc_write,
   input  logic [STATE_W-1:0] line_state,
   input  logic               cache_req_n,
   input  logic               ken_n,
   input  logic               wb_wt,
   input  logic               pwt,
   input  logic               wa_enable,
   input  logic               wa_region,
   output logic [STATE_W-1:0] next_state,
   output logic [KIND_W-1:0]  bus_kind,
   output logic               cacheable
);

   if (STATE_W != ST_W) begin : g_bad_state_w
      $error("STATE_W must equal the package state width");
   end
   if (KIND_W != BUS_W) begin : g_bad_kind_w
      $error("KIND_W must equal the package bus-kind width");
   end

   attr_t attr;
   mesi_e cur;
   mesi_e fill_st;
   mesi_e wr_base;
   mesi_e wr_next;
   logic  wr_bus;
   logic  alloc;
   logic  hit;
   mesi_e rd_next;
   bus_e  rd_bus;
   mesi_e wr_final;
   bus_e  wr_kind;

   assign attr = '{cache_req_n: cache_req_n, ken_n: ken_n, wb_wt: wb_wt, pwt: pwt};
   assign cur  = mesi_e'(line_state);
   assign hit  = (cur != ST_I);

   if (WA_SUPPORT) begin : g_alloc
      assign alloc = wa_enable & wa_region;
   end else begin : g_no_alloc
      logic unused_wa;
      assign unused_wa = wa_enable ^ wa_region;
      assign alloc     = 1'b0;
   end

   mesi_fill_rule u_fill (
      .attr       (attr),
      .fill_state (fill_st)
   );

   assign wr_base = (!hit && alloc) ? fill_st : cur;

   mesi_write_rule u_write (
      .cur    (wr_base),
      .attr   (attr),
      .nxt    (wr_next),
      .bus_wr (wr_bus)
   );

   always_comb begin
      rd_next = hit ? cur : fill_st;
      rd_bus  = hit ? BUS_NONE : BUS_FILL;
   end

   always_comb begin
      wr_final = wr_next;
      if (hit)
         wr_kind = wr_bus ? BUS_WRITE : BUS_NONE;
      else if (alloc)
         wr_kind = wr_bus ? BUS_FILLW : BUS_FILL;
      else
         wr_kind = BUS_WRITE;
   end

   always_comb begin
      if (acc_write) begin
         next_state = wr_final;
         bus_kind   = wr_kind;
      end else begin
         next_state = rd_next;
         bus_kind   = rd_bus;
      end
      cacheable = (acc_write ? (wr_final != ST_I) : (rd_next != ST_I));
   end

endmodule

// File: rtl/mesi_state_ctrl_chk.sv
module mesi_state_ctrl_chk #(
   parameter bit WA_SUPPORT = 1'b1
)(
   input logic       acc_write,
   input logic [1:0] line_state,
   input logic       cache_req_n,
   input logic       ken_n,
   input logic       wb_wt,
   input logic       pwt,
   input logic       wa_enable,
   input logic       wa_region,
   input logic [1:0] next_state,
   input logic [1:0] bus_kind,
   input logic       cacheable
);

   logic known;
   logic alloc_on;

   always_comb begin
      known = !$isunknown({acc_write, line_state, cache_req_n, ken_n, wb_wt, pwt,
                           wa_enable, wa_region, next_state, bus_kind, cacheable});
      alloc_on = WA_SUPPORT && wa_enable && wa_region;
      if (known) begin
         if (!acc_write && line_state != 2'd0)
            AST_READ_HIT_HOLD: assert (next_state == line_state && bus_kind == 2'd0); // R1
         if (!acc_write && line_state == 2'd0)
            AST_READ_MISS_FILL: assert (bus_kind == 2'd1 && next_state != 2'd3); // R2
         if (!acc_write && line_state == 2'd0 && (cache_req_n || ken_n))
            AST_READ_UNCACHED: assert (next_state == 2'd0 && !cacheable); // R4
         if (acc_write && line_state[1])
            AST_WRITE_DIRTY: assert (next_state == 2'd3 && bus_kind == 2'd0); // R5
         if (acc_write && line_state == 2'd1)
            AST_WRITE_SHARED: assert (bus_kind == 2'd2 && next_state != 2'd3 && next_state != 2'd0); // R6
         if (acc_write && line_state == 2'd0 && !alloc_on)
            AST_WRITE_MISS_PLAIN: assert (bus_kind == 2'd2 && next_state == 2'd0); // R7
         if (acc_write && line_state == 2'd0 && alloc_on)
            AST_ALLOC_HAS_FILL: assert (bus_kind[0] && next_state != 2'd2); // R8
         AST_CACHEABLE_MATCH: assert (cacheable == (next_state != 2'd0)); // R10
      end
   end

endmodule

bind mesi_state_ctrl mesi_state_ctrl_chk #(.WA_SUPPORT(WA_SUPPORT)) u_chk (
   .acc_write   (acc_write),
   .line_state  (line_state),
   .cache_req_n (cache_req_n),
   .ken_n       (ken_n),
   .wb_wt       (wb_wt),
   .pwt         (pwt),
   .wa_enable   (wa_enable),
   .wa_region   (wa_region),
   .next_state  (next_state),
   .bus_kind    (bus_kind),
   .cacheable   (cacheable)
);

// File: tb/test_mesi_state_ctrl.sv
module test_mesi_state_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_write, cache_req_n, ken_n, wb_wt, pwt, wa_enable, wa_region;
   logic [1:0] line_state;
   logic [1:0] next_state, bus_kind;
   logic       cacheable;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   mesi_state_ctrl i_mesi_state_ctrl (
      .acc_write   (acc_write),
      .line_state  (line_state),
      .cache_req_n (cache_req_n),
      .ken_n       (ken_n),
      .wb_wt       (wb_wt),
      .pwt         (pwt),
      .wa_enable   (wa_enable),
      .wa_region   (wa_region),
      .next_state  (next_state),
      .bus_kind    (bus_kind),
      .cacheable   (cacheable)
   );

   // behavioural model: expected state, bus kind and the requirement it covers
   int    exp_st, exp_bus;
   string exp_req;

   task automatic model();
      int keep, fill;
      keep = (cache_req_n == 0 && ken_n == 0);
      if (!keep)                 fill = 0;
      else if (wb_wt == 1 && pwt == 0) fill = 2;
      else                       fill = 1;
      if (acc_write == 0) begin
         if (line_state != 0) begin exp_st = line_state; exp_bus = 0; exp_req = "R1"; end
         else begin
            exp_st = fill; exp_bus = 1;
            exp_req = (fill == 2) ? "R2" : (fill == 1) ? "R3" : "R4";
         end
      end else begin
         case (line_state)
            3, 2: begin exp_st = 3; exp_bus = 0; exp_req = "R5"; end
            1: begin exp_st = (wb_wt == 1 && pwt == 0) ? 2 : 1; exp_bus = 2; exp_req = "R6"; end
            default: begin
               if (!(wa_enable && wa_region)) begin exp_st = 0; exp_bus = 2; exp_req = "R7"; end
               else if (fill == 2) begin exp_st = 3; exp_bus = 1; exp_req = "R8"; end
               else begin exp_st = fill; exp_bus = 3; exp_req = "R9"; end
            end
         endcase
      end
   endtask

   task automatic compare();
      model();
      total++;
      if (next_state !== exp_st[1:0] || bus_kind !== exp_bus[1:0]) begin
         bad++;
         $display("FAIL %s: vec w=%0d st=%0d attr=%b%b%b%b wa=%b%b got st=%0d bus=%0d exp st=%0d bus=%0d",
                  exp_req, acc_write, line_state, cache_req_n, ken_n, wb_wt, pwt,
                  wa_enable, wa_region, next_state, bus_kind, exp_st, exp_bus);
      end
      total++;
      if (cacheable !== (exp_st != 0)) begin
         bad++;
         $display("FAIL R10: cacheable got %b exp %b", cacheable, (exp_st != 0));
      end
   endtask

   initial begin
      {acc_write, line_state, cache_req_n, ken_n, wb_wt, pwt, wa_enable, wa_region} = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare();   // reset-time idle vector: read of I, cacheable writethrough (R3)
      rst_n = 1'b1;
      for (int v = 0; v < 512; v++) begin
         @(posedge clk);
         {acc_write, line_state, cache_req_n, ken_n, wb_wt, pwt, wa_enable, wa_region} = v[8:0];
         @(negedge clk);
         compare();
      end
      // allocating write miss across attribute patterns, walked in reverse (R8, R9)
      for (int a = 15; a >= 0; a--) begin
         @(posedge clk);
         acc_write = 1'b1; line_state = 2'd0; wa_enable = 1'b1; wa_region = 1'b1;
         {cache_req_n, ken_n, wb_wt, pwt} = a[3:0];
         @(negedge clk);
         compare();
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule